// File: doc/BRIEF.md
# Iterative 1280-bit Round Permutation Engine

This block applies a fixed, keyless permutation to a 1280-bit state held as a 4-row by 5-column grid of 64-bit words. One full round is computed every clock. A run consists of either a short schedule of 6 rounds or a long schedule of 12 rounds, chosen when the run starts. It is the compute core of an authenticated-encryption datapath. The surrounding mode logic writes a state in, pulses start, waits for done and reads the state back.

Each round applies five steps in a fixed order:
- a column mix over GF(2^5);
- a fixed rotation of each word;
- an affine reordering of the words;
- a 5-bit nonlinear substitution across the columns;
- the XOR of a round constant into one word.

The round constants come from a companion 64-bit LFSR. The LFSR is reseeded at every start and steps once per round.

Top module: `icp_perm_core`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `state_o` is all zeros.
- R2: The word in row x (0..3), column y (0..4) occupies bits [64*(x+4*y) +: 64] of `state_i` and `state_o`. Bit z of that word is flat bit 64*(x+4*y)+z.
- R3: Column mix step. For each row x and bit z, a 5-bit element e_x is formed with bit y = bit z of word (x,y). The new elements are: o0 = 2e0+e1+e2+e3, o1 = e0+e1+18e2+2e3, o2 = e0+2e1+e2+18e3, o3 = e0+18e1+2e2+e3. Products are in GF(2^5) modulo x^5+x^2+1, and + is XOR. o_x is written back with the same bit layout.
- R4: Rotation step. Word (x,y) is rotated left, toward higher bit index, by the amount at position y of row x in this table. Row 0: 0,36,3,41,18. Row 1: 1,44,10,45,2. Row 2: 62,6,43,15,61. Row 3: 28,55,25,21,56.
- R5: Reorder step. Word (x,y) moves to row x'=(x+y) mod 4 and column y'=(x'+y+1) mod 5.
- R6: Substitution step. For each row x and bit z, m_k is bit z of word (x,k). The output is z_k = m_k ^ (~m_{k+1} & m_{k+2}) ^ AND(all m) ^ AND(all ~m), with indices taken mod 5. z_k is written to bit z of word (x,k).
- R7: Constant step. The round constant is XORed into word (0,0) only. Round 1 of a run uses the seed 64'h0123456789ABCDEF. Each later round uses the next LFSR value, {c[62:0], c[63]^c[62]^c[60]^c[59]}.
- R8: Within a round the steps are applied in the order mix, rotate, reorder, substitute, constant. `state_o` shows the state after round k at the k-th clock after the start is taken.
- R9: A start taken with `long_i`=1 runs 12 rounds; with `long_i`=0 it runs 6 rounds. `busy_o` is high for exactly that many cycles.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last round. From then on `state_o` holds the result until the next start is taken.
- R11: A start pulse while `busy_o` is high is ignored. It changes neither the state, the round count nor the schedule.
- R12: The state after the sixth round of a 12-round run equals the result of a 6-round run on the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads `state_i` and the schedule when idle |
| long_i | input | 1 | Schedule select sampled at start: 1 = 12 rounds, 0 = 6 rounds |
| state_i | input | 1280 | State to permute |
| state_o | output | 1280 | Current state; final result once done |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench builds the core with its default parameters: schedules of 6 and 12 rounds and the standard constant seed. With these values both schedule lengths and the full constant sequence of a long run are exercised. The scoreboard compares every intermediate round state, not only the final one. A single wrong rotation amount, matrix coefficient, word destination or LFSR tap therefore shows up in the first round it affects. Sampling the long run at round six also brings the prefix relation between the two schedules within reach.

// File: rtl/icp_pkg.sv
package icp_pkg;
    localparam int ROWS    = 4;
    localparam int COLS    = 5;
    localparam int WORD_W  = 64;
    localparam int STATE_W = ROWS * COLS * WORD_W;
    localparam int ELEM_W  = 5;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [STATE_W-1:0] state_t;

    function automatic int wbase(input int x, input int y);
        return WORD_W * (x + ROWS * y);
    endfunction

    // multiply by x in GF(2^5), reduction polynomial x^5+x^2+1
    function automatic logic [4:0] gf_dbl(input logic [4:0] a);
        return {a[3:0], 1'b0} ^ (a[4] ? 5'b00101 : 5'b00000);
    endfunction

    function automatic state_t mix_step(input state_t s);
        state_t r;
        logic [4:0] e [ROWS];
        logic [4:0] o [ROWS];
        logic [4:0] d [ROWS];
        logic [4:0] h [ROWS];
        r = s;
        for (int z = 0; z < WORD_W; z++) begin
            for (int x = 0; x < ROWS; x++) begin
                for (int y = 0; y < COLS; y++) e[x][y] = s[wbase(x, y) + z];
                d[x] = gf_dbl(e[x]);
                h[x] = gf_dbl(gf_dbl(gf_dbl(d[x]))) ^ d[x];   // times 18
            end
            o[0] = d[0] ^ e[1] ^ e[2] ^ e[3];
            o[1] = e[0] ^ e[1] ^ h[2] ^ d[3];
            o[2] = e[0] ^ d[1] ^ e[2] ^ h[3];
            o[3] = e[0] ^ h[1] ^ d[2] ^ e[3];
            for (int x = 0; x < ROWS; x++)
                for (int y = 0; y < COLS; y++) r[wbase(x, y) + z] = o[x][y];
        end
        return r;
    endfunction

    function automatic int rot_amount(input int x, input int y);
        case (x * COLS + y)
            0: return 0;   1: return 36;  2: return 3;   3: return 41;  4: return 18;
            5: return 1;   6: return 44;  7: return 10;  8: return 45;  9: return 2;
            10: return 62; 11: return 6;  12: return 43; 13: return 15; 14: return 61;
            15: return 28; 16: return 55; 17: return 25; 18: return 21; default: return 56;
        endcase
    endfunction

    function automatic state_t rotate_step(input state_t s);
        state_t r;
        word_t  w;
        int     n;
        for (int x = 0; x < ROWS; x++)
            for (int y = 0; y < COLS; y++) begin
                w = s[wbase(x, y) +: WORD_W];
                n = rot_amount(x, y);
                if (n != 0) w = (w << n) | (w >> (WORD_W - n));
                r[wbase(x, y) +: WORD_W] = w;
            end
        return r;
    endfunction

    function automatic state_t reorder_step(input state_t s);
        state_t r;
        int xn, yn;
        for (int x = 0; x < ROWS; x++)
            for (int y = 0; y < COLS; y++) begin
                xn = (x + y) % ROWS;
                yn = (xn + y + 1) % COLS;
                r[wbase(xn, yn) +: WORD_W] = s[wbase(x, y) +: WORD_W];
            end
        return r;
    endfunction
endpackage

// File: rtl/icp_sbox5.sv
module icp_sbox5 (
    input  logic [4:0] m_i,
    output logic [4:0] z_o
);
    logic all_hi, all_lo;

    always_comb begin
        all_hi = &m_i;
        all_lo = ~|m_i;
        for (int k = 0; k < 5; k++)
            z_o[k] = m_i[k] ^ (~m_i[(k + 1) % 5] & m_i[(k + 2) % 5]) ^ all_hi ^ all_lo;
    end
endmodule

// File: rtl/icp_round.sv
module icp_round
    import icp_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic [WORD_W-1:0]  rc_i,
    output logic [STATE_W-1:0] state_o
);
    logic [STATE_W-1:0] mix_s, rot_s, ord_s, sub_s;

    always_comb begin
        mix_s = mix_step(state_i);
        rot_s = rotate_step(mix_s);
        ord_s = reorder_step(rot_s);
    end

    for (genvar gx = 0; gx < ROWS; gx++) begin : g_row
        for (genvar gz = 0; gz < WORD_W; gz++) begin : g_bit
            logic [4:0] m_in, z_out;
            for (genvar gk = 0; gk < COLS; gk++) begin : g_col
                localparam int BIT = WORD_W * (gx + ROWS * gk) + gz;
                assign m_in[gk]   = ord_s[BIT];
                assign sub_s[BIT] = z_out[gk];
            end
            icp_sbox5 u_sbox (.m_i(m_in), .z_o(z_out));
        end
    end

    assign state_o = {sub_s[STATE_W-1:WORD_W], sub_s[WORD_W-1:0] ^ rc_i};
endmodule

// File: rtl/icp_rc_gen.sv
module icp_rc_gen #(
    parameter logic [63:0] SEED = 64'h0123456789ABCDEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic        step_i,
    output logic [63:0] rc_o
);
    logic [63:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load_i)      lfsr_d = SEED;
        else if (step_i) lfsr_d = {lfsr_q[62:0], lfsr_q[63] ^ lfsr_q[62] ^ lfsr_q[60] ^ lfsr_q[59]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rc_o = lfsr_q;

    p_seed_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> rc_o == SEED);
    p_lfsr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> rc_o[63:1] == $past(rc_o[62:0]));
endmodule

// File: rtl/icp_perm_core.sv
module icp_perm_core
    import icp_pkg::*;
#(
    parameter int          SHORT_ROUNDS = 6,
    parameter int          LONG_ROUNDS  = 12,
    parameter logic [63:0] RC_SEED      = 64'h0123456789ABCDEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               long_i,
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] state_o,
    output logic               busy_o,
    output logic               done_o
);
    localparam int CNT_W = $clog2(LONG_ROUNDS + 1);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   last;
        logic [STATE_W-1:0] st;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic               take;
    logic [WORD_W-1:0]  rc;
    logic [STATE_W-1:0] rnd_out;

    icp_rc_gen #(.SEED(RC_SEED)) u_rc (
        .clk(clk), .rst_n(rst_n), .load_i(take), .step_i(ctl_q.busy), .rc_o(rc)
    );

    icp_round u_round (.state_i(ctl_q.st), .rc_i(rc), .state_o(rnd_out));

    always_comb begin
        take       = start_i && !ctl_q.busy;
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (take) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = '0;
            ctl_d.last = long_i ? CNT_W'(LONG_ROUNDS - 1) : CNT_W'(SHORT_ROUNDS - 1);
            ctl_d.st   = state_i;
        end else if (ctl_q.busy) begin
            ctl_d.st  = rnd_out;
            ctl_d.cnt = ctl_q.cnt + 1'b1;
            if (ctl_q.cnt == ctl_q.last) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign state_o = ctl_q.st;
    assign busy_o  = ctl_q.busy;
    assign done_o  = ctl_q.done;

    p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o && ctl_q.cnt == '0);
    p_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(ctl_q.cnt) == $past(ctl_q.last) && $past(busy_o));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(state_o));
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.cnt != ctl_q.last) |=>
            busy_o && ctl_q.cnt == $past(ctl_q.cnt) + 1'b1 && $stable(ctl_q.last));
endmodule

// File: tb/icp_perm_core_tb_top.sv
module icp_perm_core_tb_top;
    localparam int SW = 1280;
    localparam logic [63:0] SEED = 64'h0123456789ABCDEF;

    typedef logic [SW-1:0] st_t;
    typedef struct packed { st_t st; logic last; } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic long_i = 1'b0;
    st_t  state_i = '0;
    st_t  state_o;
    logic busy_o, done_o;

    int    n_checks = 0;
    int    n_errors = 0;
    item_t sb[$];
    st_t   act_log [12];
    int    act_n = 0;
    string tag_g = "";

    always #2ns clk = ~clk;

    icp_perm_core dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
        .state_i(state_i), .state_o(state_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input st_t act, input st_t exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- independent reference model ----------------
    typedef logic [63:0] w_t;
    typedef w_t grid_t [4][5];

    function automatic grid_t to_grid(input st_t s);
        grid_t g;
        for (int y = 0; y < 5; y++)
            for (int x = 0; x < 4; x++) g[x][y] = s[64*(x+4*y) +: 64];   // R2
        return g;
    endfunction

    function automatic st_t from_grid(input grid_t g);
        st_t s;
        for (int y = 0; y < 5; y++)
            for (int x = 0; x < 4; x++) s[64*(x+4*y) +: 64] = g[x][y];
        return s;
    endfunction

    function automatic logic [4:0] gmul(input logic [4:0] a, input logic [4:0] b);
        logic [8:0] p = '0;
        for (int i = 0; i < 5; i++) if (b[i]) p ^= 9'(a) << i;
        for (int i = 8; i >= 5; i--) if (p[i]) p ^= 9'b100101 << (i - 5);
        return p[4:0];
    endfunction

    function automatic grid_t m_mix(input grid_t g);   // R3
        int    coef [4][4] = '{'{2,1,1,1}, '{1,1,18,2}, '{1,2,1,18}, '{1,18,2,1}};
        grid_t r;
        logic [4:0] e [4];
        logic [4:0] acc;
        for (int z = 0; z < 64; z++) begin
            for (int x = 0; x < 4; x++)
                for (int y = 0; y < 5; y++) e[x][y] = g[x][y][z];
            for (int i = 0; i < 4; i++) begin
                acc = '0;
                for (int j = 0; j < 4; j++) acc ^= gmul(e[j], 5'(coef[i][j]));
                for (int y = 0; y < 5; y++) r[i][y][z] = acc[y];
            end
        end
        return r;
    endfunction

    function automatic grid_t m_rot(input grid_t g);   // R4
        int offs [4][5] = '{'{0,36,3,41,18}, '{1,44,10,45,2},
                            '{62,6,43,15,61}, '{28,55,25,21,56}};
        grid_t r;
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 5; y++)
                for (int z = 0; z < 64; z++) r[x][y][(z + offs[x][y]) % 64] = g[x][y][z];
        return r;
    endfunction

    function automatic grid_t m_move(input grid_t g);  // R5
        grid_t r;
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 5; y++) r[(x+y)%4][(((x+y)%4)+y+1)%5] = g[x][y];
        return r;
    endfunction

    function automatic grid_t m_sub(input grid_t g);   // R6
        grid_t r;
        logic [4:0] m;
        for (int x = 0; x < 4; x++)
            for (int z = 0; z < 64; z++) begin
                for (int k = 0; k < 5; k++) m[k] = g[x][k][z];
                for (int k = 0; k < 5; k++)
                    r[x][k][z] = m[k] ^ (!m[(k+1)%5] && m[(k+2)%5]) ^ (m == 5'h1F) ^ (m == 5'h00);
            end
        return r;
    endfunction

    function automatic st_t m_round(input st_t s, input w_t c);  // R8 order
        grid_t g = m_sub(m_move(m_rot(m_mix(to_grid(s)))));
        g[0][0] ^= c;                                              // R7
        return from_grid(g);
    endfunction

    function automatic w_t m_next(input w_t c);
        return {c[62:0], c[63] ^ c[62] ^ c[60] ^ c[59]};
    endfunction

    // ---------------- monitor ----------------
    initial begin
        bit prev_busy = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_busy) begin
                    if (sb.size() == 0) begin
                        check(0, "R9", "unexpected round output", state_o, '0);
                    end else begin
                        it = sb.pop_front();
                        check(state_o === it.st, tag_g, "round state", state_o, it.st);
                        check(done_o === it.last, "R10", "done timing", st_t'(done_o), st_t'(it.last));
                        check(busy_o === !it.last, "R9", "busy length", st_t'(busy_o), st_t'(!it.last));
                        if (act_n < 12) act_log[act_n] = state_o;
                        act_n++;
                    end
                end
                prev_busy = busy_o;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run(input st_t st, input bit lng, input string tag, input bit poke,
                       output st_t result);
        int  n = lng ? 12 : 6;
        w_t  c = SEED;
        st_t s = st;
        for (int k = 0; k < n; k++) begin
            s = m_round(s, c);
            c = m_next(c);
            sb.push_back('{st: s, last: (k == n - 1)});
        end
        result = s;
        act_n  = 0;
        tag_g  = tag;
        @(negedge clk);
        state_i = st; long_i = lng; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            state_i = ~st; long_i = !lng; start_i = 1'b1;   // R11 ignored start
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(state_o === result, "R10", "result held", state_o, result);
        check(!busy_o && !done_o, "R10", "idle after run", st_t'({busy_o, done_o}), '0);
    endtask

    function automatic st_t rand_state();
        st_t s;
        for (int i = 0; i < SW / 32; i++) s[32*i +: 32] = $urandom;
        return s;
    endfunction

    initial begin
        #(4ns * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        st_t r6, r12, inp, one;
        repeat (3) @(negedge clk);
        check(state_o === '0, "R1", "reset state", state_o, '0);
        check(!busy_o && !done_o, "R1", "reset flags", st_t'({busy_o, done_o}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1", "idle after reset", st_t'({busy_o, done_o}), '0);

        // all-zero state: substitution of zero and constant injection
        run('0, 1'b0, "R6 R7", 1'b0, r6);

        // single bit in word (1,2) bit 5: layout, mix, rotate, reorder
        one = '0;
        one[64*(1+4*2) + 5] = 1'b1;
        run(one, 1'b0, "R2 R3 R4 R5", 1'b0, r6);

        // patterned state on the long schedule
        for (int i = 0; i < 20; i++) inp[64*i +: 64] = {32'(i * 32'h9E3779B9), 32'hA5A5_0000 | 32'(i)};
        run(inp, 1'b1, "R8 R9", 1'b0, r12);

        // random input: short then long, compare prefix
        inp = rand_state();
        run(inp, 1'b0, "R8 R9", 1'b0, r6);
        run(inp, 1'b1, "R8 R12", 1'b0, r12);
        check(act_log[5] === r6, "R12", "long run round six vs short result", act_log[5], r6);

        // start during busy is ignored
        inp = rand_state();
        run(inp, 1'b0, "R11", 1'b1, r6);
        run(rand_state(), 1'b1, "R11", 1'b1, r12);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule